// File: doc/BRIEF.md
# Tree-Based Binary Magnitude Comparator

This block compares two unsigned N-bit operands, A and B, and reports exactly one of three outcomes: B is larger, the two are equal, or A is larger. It does not subtract and it does not scan the bits from the top down one at a time. Each bit position is first reduced to a pair of signals: one says B wins at that bit, the other says the two bits match. A balanced binary tree of identical merge cells then joins neighbouring groups. At each cell the more significant group decides the result unless its bits are all equal. The path length therefore grows with log2(N).

The operands are captured into an input register when the input valid is high. The tree between the two register stages is purely combinational. The three flags and an output valid are registered, so a result follows its operands by one clock and a new operand pair can be accepted every cycle. N must be a power of two and at least 2; the default is 64.

Top module: `mag_cmp_tree`

## Requirements
- R1: Operands presented with `in_valid` high at rising edge t are captured at t. The matching flags and `out_valid` = 1 are registered at edge t+1. Consecutive valid cycles produce results on consecutive cycles, in order.
- R2: When `out_valid` is 1, `b_gt` is 1 exactly when B > A, comparing both operands as unsigned numbers.
- R3: When `out_valid` is 1, `a_eq` is 1 exactly when A == B.
- R4: When `out_valid` is 1, `b_lt` is 1 exactly when A > B. Exactly one of `b_gt`, `a_eq` and `b_lt` is 1.
- R5: In a cycle where `out_valid` is 0, all three flags are 0. `out_valid` is 0 on the cycle after an edge with `in_valid` low, even if the operands change.
- R6: The most significant unequal bit alone decides the result. Operands that differ only in bit 0 are ordered by bit 0. A difference in bit N-1 outranks any pattern in the lower bits.
- R7: A synchronous active-high `rst` clears `out_valid` and all flags at the next rising edge. This includes a result already in flight, and no stale result appears on the edge after reset is released.
- R8: The same logic gives correct results for N = 4 over every operand pair, and for N = 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture `op_a`/`op_b` on this edge |
| op_a | input | N | Operand A, unsigned |
| op_b | input | N | Operand B, unsigned |
| out_valid | output | 1 | Flags hold a fresh result |
| b_gt | output | 1 | B greater than A |
| a_eq | output | 1 | A equal to B |
| b_lt | output | 1 | B less than A |

## Verification
Random 64-bit operands are almost never equal, and almost never agree on every bit above the lowest. Without help, the equal-flag path and the deep chain through the tree's lowest cells would hardly be exercised. The stimulus therefore builds pairs from one random word: a copy, a copy with only bit 0 flipped, a copy with only bit 63 flipped, and a fully independent pair. A fixed table adds alternating-bit and near-boundary words. The 4-bit instance receives all 256 pairs. This covers every combination of merge-cell inputs at both tree levels.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  // Per-group comparison summary: gt = B wins in this group, eq = all bits match
  typedef struct packed {
    logic gt;
    logic eq;
  } grp_t;

endpackage

// File: rtl/cmp_preenc.sv
module cmp_preenc
  import cmp_pkg::*;
#(
  parameter int N = 64
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output grp_t [N-1:0] leaf
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign leaf[i] = '{gt: (b[i] & ~a[i]), eq: ~(a[i] ^ b[i])};
  end

endmodule

// File: rtl/cmp_merge.sv
module cmp_merge
  import cmp_pkg::*;
(
  input  grp_t hi,
  input  grp_t lo,
  output grp_t grp
);

  // The upper group decides unless all of its bits match
  assign grp.gt = hi.gt | (hi.eq & lo.gt);
  assign grp.eq = hi.eq & lo.eq;

endmodule

// File: rtl/cmp_tree.sv
module cmp_tree
  import cmp_pkg::*;
#(
  parameter int N = 64
) (
  input  grp_t [N-1:0] leaf,
  output grp_t         root
);

  // Heap layout: node 0 is the root; node k has children 2k+1 (lower bits) and
  // 2k+2 (upper bits); bit i sits in node N-1+i.
  localparam int NODES = 2 * N - 1;
  localparam int INNER = N - 1;

  grp_t node [NODES];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign node[INNER + i] = leaf[i];
  end

  for (genvar k = 0; k < INNER; k++) begin : g_cell
    cmp_merge u_merge (
      .hi  (node[2 * k + 2]),
      .lo  (node[2 * k + 1]),
      .grp (node[k])
    );
  end

  assign root = node[0];

endmodule

// File: rtl/mag_cmp_tree.sv
module mag_cmp_tree
  import cmp_pkg::*;
#(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  output logic         out_valid,
  output logic         b_gt,
  output logic         a_eq,
  output logic         b_lt
);

  if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_width
    $error("mag_cmp_tree: N must be a power of two and at least 2");
  end

  logic [N-1:0] a_q;
  logic [N-1:0] b_q;
  logic         stg_v;
  grp_t [N-1:0] leaf;
  grp_t         root;

  // Input stage
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_v <= 1'b0;
    end else begin
      stg_v <= in_valid;
    end
    if (in_valid) begin
      a_q <= op_a;
      b_q <= op_b;
    end
  end

  cmp_preenc #(.N(N)) u_preenc (
    .a    (a_q),
    .b    (b_q),
    .leaf (leaf)
  );

  cmp_tree #(.N(N)) u_tree (
    .leaf (leaf),
    .root (root)
  );

  // Output stage: flags are cleared whenever no fresh result is present
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      b_gt      <= 1'b0;
      a_eq      <= 1'b0;
      b_lt      <= 1'b0;
    end else begin
      out_valid <= stg_v;
      if (stg_v) begin
        b_gt <= root.gt;
        a_eq <= root.eq;
        b_lt <= ~root.gt & ~root.eq;
      end else begin
        b_gt <= 1'b0;
        a_eq <= 1'b0;
        b_lt <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cmp_tree_chk.sv
module cmp_tree_chk #(
  parameter int N = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [N-1:0] op_a,
  input logic [N-1:0] op_b,
  input logic         out_valid,
  input logic         b_gt,
  input logic         a_eq,
  input logic         b_lt
);

  logic         rv1, rv2;
  logic [N-1:0] ra1, rb1, ra2, rb2;

  always_ff @(posedge clk) begin
    if (rst) begin
      rv1 <= 1'b0;
      rv2 <= 1'b0;
    end else begin
      rv1 <= in_valid;
      rv2 <= rv1;
    end
    if (in_valid) begin
      ra1 <= op_a;
      rb1 <= op_b;
    end
    ra2 <= ra1;
    rb2 <= rb1;
  end

  a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == rv2);

  a_r2_gt_ref: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (b_gt == (rb2 > ra2)));

  a_r3_eq_ref: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (a_eq == (rb2 == ra2)));

  a_r4_lt_ref: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (b_lt == (ra2 > rb2)));

  a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones({b_gt, a_eq, b_lt}) == 1));

  a_r5_idle_clear: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ({b_gt, a_eq, b_lt} == 3'b000));

  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && {b_gt, a_eq, b_lt} == 3'b000));

endmodule

bind mag_cmp_tree cmp_tree_chk #(.N(N)) u_chk (.*);

// File: tb/test_mag_cmp_tree.sv
module test_mag_cmp_tree;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic [63:0] a64 = '0, b64 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic ov64, gt64, eq64, lt64;
  logic ov4, gt4, eq4, lt4;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  mag_cmp_tree #(.N(64)) i_mag_cmp_tree (
    .clk(clk), .rst(rst), .in_valid(vld), .op_a(a64), .op_b(b64),
    .out_valid(ov64), .b_gt(gt64), .a_eq(eq64), .b_lt(lt64)
  );

  mag_cmp_tree #(.N(4)) i_mag_cmp_tree_n4 (
    .clk(clk), .rst(rst), .in_valid(vld), .op_a(a4), .op_b(b4),
    .out_valid(ov4), .b_gt(gt4), .a_eq(eq4), .b_lt(lt4)
  );

  // Table: operand A, operand B, expected {b_gt, a_eq, b_lt}
  localparam logic [63:0] TV_A [12] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h1,
    64'h8000_0000_0000_0000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFE, 64'h5555_5555_5555_5555,
    64'hAAAA_AAAA_AAAA_AAAA, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'h0123_4567_89AB_CDEF};
  localparam logic [63:0] TV_B [12] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0,
    64'h0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA,
    64'h5555_5555_5555_5555, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF};
  localparam logic [2:0] TV_E [12] = '{
    3'b010, 3'b010, 3'b100, 3'b001,
    3'b001, 3'b100, 3'b100, 3'b100,
    3'b001, 3'b100, 3'b001, 3'b010};

  function automatic logic [2:0] expect3(input logic [63:0] a, input logic [63:0] b);
    return {b > a, b == a, a > b};
  endfunction

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got {valid,gt,eq,lt}=%b expected %b", req, got, exp);
    end
  endtask

  // Present one pair to both instances, then sample the result one edge after capture
  task automatic run_pair(input logic [63:0] a, input logic [63:0] b,
                          input logic [3:0] sa, input logic [3:0] sb,
                          input string req, input logic [2:0] exp64);
    @(negedge clk);
    vld = 1'b1; a64 = a; b64 = b; a4 = sa; b4 = sb;
    @(posedge clk);
    @(negedge clk);
    vld = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(req, {ov64, gt64, eq64, lt64}, {1'b1, exp64});
    chk("R8 N=4", {ov4, gt4, eq4, lt4}, {1'b1, expect3({60'd0, sa}, {60'd0, sb})});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1: watchdog expired, got hung run expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [63:0] r;
    logic [63:0] rb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset state
    chk("R7 reset state", {ov64, gt64, eq64, lt64}, 4'b0000);
    chk("R7 reset state N=4", {ov4, gt4, eq4, lt4}, 4'b0000);
    rst = 1'b0;

    // Table walk: R2 R3 R4 R6
    for (int i = 0; i < 12; i++) begin
      if (TV_E[i] !== expect3(TV_A[i], TV_B[i])) begin
        n_bad++;
        $display("FAIL R2: table row %0d inconsistent got %b expected %b", i, TV_E[i], expect3(TV_A[i], TV_B[i]));
      end
      run_pair(TV_A[i], TV_B[i], TV_A[i][3:0], TV_B[i][3:0], "R2/R3/R4/R6 table", TV_E[i]);
    end

    // Exhaustive N=4 (R8) alongside patterned random N=64 (R6, R2, R3, R4)
    for (int ai = 0; ai < 16; ai++) begin
      for (int bi = 0; bi < 16; bi++) begin
        r = {$urandom, $urandom};
        case ((ai * 16 + bi) % 4)
          0: rb = r;
          1: rb = r ^ 64'h1;
          2: rb = r ^ 64'h8000_0000_0000_0000;
          default: rb = {$urandom, $urandom};
        endcase
        run_pair(r, rb, ai[3:0], bi[3:0], "R6 random N=64", expect3(r, rb));
      end
    end

    // R5: idle cycle with changing operands leaves outputs cleared
    @(negedge clk);
    vld = 1'b0; a64 = 64'h0; b64 = 64'hFFFF; a4 = 4'h0; b4 = 4'hF;
    @(posedge clk);
    @(negedge clk);
    chk("R5 idle clear", {ov64, gt64, eq64, lt64}, 4'b0000);
    chk("R5 idle clear N=4", {ov4, gt4, eq4, lt4}, 4'b0000);

    // R1: back-to-back valid cycles, results in order
    @(negedge clk);
    vld = 1'b1; a64 = 64'd5; b64 = 64'd9; a4 = 4'd5; b4 = 4'd9;
    @(posedge clk);
    @(negedge clk);
    a64 = 64'd9; b64 = 64'd5; a4 = 4'd9; b4 = 4'd5;
    @(posedge clk);
    @(negedge clk);
    vld = 1'b0;
    chk("R1 first of burst", {ov64, gt64, eq64, lt64}, 4'b1100);
    chk("R1 first of burst N=4", {ov4, gt4, eq4, lt4}, 4'b1100);
    @(posedge clk);
    @(negedge clk);
    chk("R1 second of burst", {ov64, gt64, eq64, lt64}, 4'b1001);
    chk("R1 second of burst N=4", {ov4, gt4, eq4, lt4}, 4'b1001);
    @(posedge clk);
    @(negedge clk);
    chk("R1 burst end", {ov64, gt64, eq64, lt64}, 4'b0000);

    // R7: reset kills a result in flight
    @(negedge clk);
    vld = 1'b1; a64 = 64'd3; b64 = 64'd3; a4 = 4'd3; b4 = 4'd3;
    @(posedge clk);
    @(negedge clk);
    vld = 1'b0; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R7 reset in flight", {ov64, gt64, eq64, lt64}, 4'b0000);
    chk("R7 reset in flight N=4", {ov4, gt4, eq4, lt4}, 4'b0000);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R7 no stale result", {ov64, gt64, eq64, lt64}, 4'b0000);

    // R8: recovery after reset
    run_pair(64'hFFFF_0000_0000_0000, 64'hFFFF_0000_0000_0001, 4'hE, 4'hF, "R8 after reset", 3'b100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule